// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit builds a linear address from up to five parts. A segment base is picked from a bank of segment base slots by a 3-bit selector code. To it are added an optional base register value, an optional index register value scaled by 1, 2, 4 or 8, and an optional 32-bit signed displacement. The sum is 64 bits wide and wraps on overflow. The result is registered, so it appears one clock after the request.

Alongside the address, the unit checks the addressing form. The form is illegal in any of these cases: the selector code names no slot, the index is the stack-pointer register, a scale is given with no index, or neither a base nor a displacement is present. In each of these cases the unit raises an error flag and drives a zero address. A consumer in an address-generation pipeline puts one request on the inputs with `in_vld` high. One cycle later it reads the address and the error flag.

Top module: `ea_gen`

## Requirements
- R1: One cycle after a request, `out_addr` equals (segment base + base + (index << scale) + sign-extended displacement) mod 2^64. The scale code is a shift amount: 0 means ×1, 1 means ×2, 2 means ×4 and 3 means ×8.
- R2: A part whose valid flag is low adds zero to the sum, whatever its value input holds. When `idx_vld` is low, `idx_num` is ignored.
- R3: Selector codes 0 to 5 pick slot k, which is bits [64k+63:64k] of `seg_bases`. Codes 6 and 7 set `out_err`.
- R4: An index that is present and numbered 4 (the stack-pointer register) sets `out_err`. Any other index number is legal.
- R5: A nonzero scale code with `idx_vld` low sets `out_err`. Scale code 0 with no index is legal.
- R6: A request with both `base_vld` and `disp_vld` low sets `out_err`. A base alone is a legal form, and so is a displacement alone.
- R7: Whenever `out_err` is high, `out_addr` is zero.
- R8: After reset, `out_vld`, `out_err` and `out_addr` are zero. `out_vld` is high exactly one cycle after each cycle in which `in_vld` is high.
- R9: In a cycle with `in_vld` low, `out_addr` and `out_err` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request strobe |
| seg_code | input | 3 | Segment slot selector |
| seg_bases | input | 384 | Six 64-bit segment bases, slot k at bits [64k+63:64k] |
| base_vld | input | 1 | Base register present |
| base_val | input | 64 | Base register value |
| idx_vld | input | 1 | Index register present |
| idx_num | input | 4 | Index register number |
| idx_val | input | 64 | Index register value |
| scale | input | 2 | Scale shift code |
| disp_vld | input | 1 | Displacement present |
| disp | input | 32 | Signed displacement |
| out_vld | output | 1 | Result valid |
| out_addr | output | 64 | Linear address, zero on error |
| out_err | output | 1 | Illegal addressing form |

## Verification
The hardest case to reach from the ports combines a negative displacement, a large base and the segment offset so that the sum crosses 2^64. A wrong sign extension or a lost wrap then still gives a plausible address. The vector table includes a request whose base and segment base sum to exactly 2^64, and another whose displacement is negative. Other vectors put deliberately non-zero values on the inputs of absent parts, and one puts register 4 on an absent index. This shows that a valid flag, and not the value, decides whether a part counts.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW     = 64,
  parameter int DW     = 32,
  parameter int RW     = 4,
  parameter int SCW    = 2,
  parameter int SELW   = 3,
  parameter int NSEG   = 6,
  parameter int SP_REG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic [SELW-1:0]    seg_code,
  input  logic [NSEG*AW-1:0] seg_bases,
  input  logic               base_vld,
  input  logic [AW-1:0]      base_val,
  input  logic               idx_vld,
  input  logic [RW-1:0]      idx_num,
  input  logic [AW-1:0]      idx_val,
  input  logic [SCW-1:0]     scale,
  input  logic               disp_vld,
  input  logic [DW-1:0]      disp,
  output logic               out_vld,
  output logic [AW-1:0]      out_addr,
  output logic               out_err
);

  localparam logic [SELW-1:0] SEG_LIM = SELW'(NSEG);
  localparam logic [RW-1:0]   SP_NUM  = RW'(SP_REG);

  logic [AW-1:0] seg_t;
  logic [AW-1:0] base_t, idx_t, disp_t, sum;
  logic          bad;

  always_comb begin
    seg_t = '0;
    for (int k = 0; k < NSEG; k++)
      if (seg_code == SELW'(k)) seg_t = seg_bases[k*AW +: AW];
  end

  assign base_t = base_vld ? base_val : '0;
  assign idx_t  = idx_vld ? (idx_val << scale) : '0;
  assign disp_t = disp_vld ? {{(AW-DW){disp[DW-1]}}, disp} : '0;
  assign sum    = seg_t + base_t + idx_t + disp_t;

  assign bad = (seg_code >= SEG_LIM)
             | (idx_vld & (idx_num == SP_NUM))
             | (!idx_vld & (scale != '0))
             | (!base_vld & !disp_vld);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_err  <= 1'b0;
      out_addr <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_err  <= bad;
        out_addr <= bad ? '0 : sum;
      end
    end
  end

  // R3
  seg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && seg_code >= SEG_LIM) |=> out_err);

  // R4
  sp_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && idx_vld && idx_num == SP_NUM) |=> out_err);

  // R5
  lone_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !idx_vld && scale != '0) |=> out_err);

  // R6
  no_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !base_vld && !disp_vld) |=> out_err);

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_addr == '0));

  // R8
  vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_addr) && $stable(out_err) && !out_vld));

endmodule

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [2:0]   seg_code = '0;
  logic [383:0] seg_bases;
  logic         base_vld = 1'b0, idx_vld = 1'b0, disp_vld = 1'b0;
  logic [63:0]  base_val = '0, idx_val = '0;
  logic [3:0]   idx_num = '0;
  logic [1:0]   scale = '0;
  logic [31:0]  disp = '0;
  logic         out_vld, out_err;
  logic [63:0]  out_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ea_gen u0 (.clk, .rst_n, .in_vld, .seg_code, .seg_bases, .base_vld, .base_val,
             .idx_vld, .idx_num, .idx_val, .scale, .disp_vld, .disp,
             .out_vld, .out_addr, .out_err);

  typedef struct packed {
    logic [2:0]  seg;
    logic        bv;
    logic [63:0] base;
    logic        iv;
    logic [3:0]  inum;
    logic [63:0] idx;
    logic [1:0]  sc;
    logic        dv;
    logic [31:0] disp;
    logic        eerr;
    logic [63:0] eaddr;
  } vec_t;

  // segment slot k holds (k+1) << 32
  localparam vec_t TBL [13] = '{
    '{3'd0, 1'b1, 64'h10, 1'b1, 4'd1, 64'h3, 2'd2, 1'b1, 32'h20, 1'b0, 64'h1_0000_003C},            // R1
    '{3'd1, 1'b1, 64'h1000, 1'b0, 4'd0, 64'h0, 2'd0, 1'b1, 32'hFFFF_FFF0, 1'b0, 64'h2_0000_0FF0},   // R1 negative disp
    '{3'd5, 1'b1, 64'hFFFF_FFFA_0000_0000, 1'b1, 4'd2, 64'h1, 2'd3, 1'b0, 32'h0, 1'b0, 64'h8},      // R1 wrap
    '{3'd2, 1'b0, 64'hDEAD, 1'b0, 4'd4, 64'hBEEF, 2'd0, 1'b1, 32'h7FFF_FFFF, 1'b0, 64'h3_7FFF_FFFF}, // R2
    '{3'd3, 1'b1, 64'h55, 1'b0, 4'd0, 64'h77, 2'd0, 1'b0, 32'h123, 1'b0, 64'h4_0000_0055},          // R2
    '{3'd4, 1'b1, 64'h1, 1'b1, 4'd7, 64'h100, 2'd0, 1'b0, 32'h0, 1'b0, 64'h5_0000_0101},            // R2
    '{3'd0, 1'b1, 64'h40, 1'b1, 4'd4, 64'h2, 2'd0, 1'b0, 32'h0, 1'b1, 64'h0},                       // R4
    '{3'd0, 1'b1, 64'h40, 1'b0, 4'd4, 64'h2, 2'd0, 1'b0, 32'h0, 1'b0, 64'h1_0000_0040},             // R4 absent
    '{3'd0, 1'b1, 64'h40, 1'b0, 4'd0, 64'h0, 2'd1, 1'b0, 32'h0, 1'b1, 64'h0},                       // R5
    '{3'd0, 1'b0, 64'h0, 1'b1, 4'd1, 64'h3, 2'd0, 1'b0, 32'h0, 1'b1, 64'h0},                        // R6
    '{3'd6, 1'b1, 64'h40, 1'b0, 4'd0, 64'h0, 2'd0, 1'b0, 32'h0, 1'b1, 64'h0},                       // R3
    '{3'd7, 1'b1, 64'h40, 1'b0, 4'd0, 64'h0, 2'd0, 1'b1, 32'h8, 1'b1, 64'h0},                       // R3
    '{3'd1, 1'b0, 64'h0, 1'b1, 4'd12, 64'h5, 2'd1, 1'b1, 32'h0, 1'b0, 64'h2_0000_000A}              // R3 slot 1
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    seg_code = v.seg; base_vld = v.bv; base_val = v.base;
    idx_vld = v.iv; idx_num = v.inum; idx_val = v.idx;
    scale = v.sc; disp_vld = v.dv; disp = v.disp;
  endtask

  initial begin
    for (int k = 0; k < 6; k++) seg_bases[k*64 +: 64] = 64'(k + 1) << 32;
    repeat (3) @(negedge clk);
    check("R8 reset vld", 64'(out_vld), 64'h0);
    check("R8 reset addr", out_addr, 64'h0);
    check("R8 reset err", 64'(out_err), 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      check($sformatf("R1/R7 vec %0d addr", i), out_addr, TBL[i].eaddr);
      check($sformatf("R3-6 vec %0d err", i), 64'(out_err), 64'(TBL[i].eerr));
      check("R8 vld", 64'(out_vld), 64'h1);
    end

    // R9: idle cycle with changed inputs keeps the last result
    drive(TBL[0]);
    @(negedge clk);
    check("R9 hold addr", out_addr, 64'h2_0000_000A);
    check("R9 hold err", 64'(out_err), 64'h0);
    check("R8 vld low", 64'(out_vld), 64'h0);

    // R7: error after a good result clears the address
    drive(TBL[6]);
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    check("R7 err addr zero", out_addr, 64'h0);
    check("R7 err flag", 64'(out_err), 64'h1);

    // R8: back-to-back requests
    drive(TBL[0]);
    in_vld = 1'b1;
    @(negedge clk);
    drive(TBL[4]);
    @(negedge clk);
    check("R8 b2b first", out_addr, 64'h4_0000_0055);
    check("R8 b2b vld", 64'(out_vld), 64'h1);
    in_vld = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule